// File: doc/BRIEF.md
# APB GPIO Controller with Pin-Change Interrupts

This block controls a bank of general-purpose pins through an APB slave port. Software programs a per-pin direction and an output value; every pin set as an output drives its data bit, and every pin set as an input is sampled. The sampled levels pass through a two-stage synchronizer and can then be read back live from a read-only register.

Each transition of a synchronized input, rising or falling, latches a per-pin status bit. Software clears a status bit by writing 1 to it. Status is masked by a per-pin enable, the masked bits are ORed together, and the result leaves the block as one registered interrupt line. Every transfer completes without wait states. An access to any address that is not one of the five register words gets an error response, changes no register, and reads back zero.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: Output data (byte offset 0x0), direction (0x4) and interrupt enable (0x10) are read-write registers, one bit per pin at bit position equal to the pin number, and read back the last value written.
- R2: After reset every register reads zero, `pin_oe` and `pin_out` are all zero and `irq` is low.
- R3: `pin_oe` equals the direction register (1 = output) and `pin_out` carries the data bit only for pins whose `pin_oe` bit is 1, zero elsewhere.
- R4: The input register (offset 0x8) shows `pin_in` after two synchronizer flops: an APB read whose access phase follows only one rising edge after a pin change still returns the old level. Writes to 0x8 have no effect.
- R5: A status bit (offset 0xC) is set on either edge of its synchronized input. The bit is visible to a read whose access phase follows the third rising edge after the pin change, and not earlier.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a pin event and a clearing write hit the same bit at the same edge, the bit stays set.
- R7: `irq` is the OR over all pins of (status AND enable), registered: it changes one clock after the status or enable change that causes it.
- R8: An access is unmapped when the address is not a multiple of 4 or the word is above 0x10, with all address bits decoded. It returns `pslverr` = 1, reads zero, and its write changes no register.
- R9: `pready` is high in every access phase, `pslverr` is low for the five mapped words, and read data is valid in the same access phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and core clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete, high in every access phase |
| pslverr | output | 1 | Error response for unmapped addresses |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output values, gated by direction |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions assume a well-formed APB master: `penable` is only raised in the cycle after a setup phase, and address, direction and write data stay unchanged through setup and access. They also assume `pin_in` is stable while reset is active, because a pin that is high at reset release counts as a rising edge. The bench drives every transfer as one setup and one access cycle on falling clock edges, keeps the pins low through reset, and changes them only between transfers or at chosen offsets from a transfer. That lets it place a pin event and a clearing write on the same edge on purpose.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned BUS_DW = 32;

  // Word index of each register (byte offset / 4); software sees these
  localparam int unsigned WIDX_DOUT = 0;
  localparam int unsigned WIDX_DIR  = 1;
  localparam int unsigned WIDX_PINS = 2;
  localparam int unsigned WIDX_STAT = 3;
  localparam int unsigned WIDX_IEN  = 4;

  typedef enum logic [2:0] {
    RSEL_DOUT,
    RSEL_DIR,
    RSEL_PINS,
    RSEL_STAT,
    RSEL_IEN,
    RSEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    logic     hit;
    reg_sel_e sel;
  } bus_req_t;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] level_o,
  output logic [NPINS-1:0] change_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [NPINS-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [NPINS-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_stage[s-1].q;
      end
    end
  end

  assign level_o = g_stage[LAST].q;

  // One extra flop holds the previous synchronized level for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_o;
  end

  assign change_o = level_o ^ prev_q;

endmodule

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output bus_req_t          req_o,
  output logic              pready_o,
  output logic              pslverr_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             access;
  logic             aligned;
  logic             hit;
  logic [IDX_W-1:0] widx;
  reg_sel_e         sel;

  always_comb begin
    access  = psel & penable;
    aligned = (paddr[1:0] == 2'b00);
    widx    = paddr[ADDR_W-1:2];
    sel     = RSEL_NONE;
    if (aligned) begin
      case (widx)
        IDX_W'(WIDX_DOUT): sel = RSEL_DOUT;
        IDX_W'(WIDX_DIR):  sel = RSEL_DIR;
        IDX_W'(WIDX_PINS): sel = RSEL_PINS;
        IDX_W'(WIDX_STAT): sel = RSEL_STAT;
        IDX_W'(WIDX_IEN):  sel = RSEL_IEN;
        default:           sel = RSEL_NONE;
      endcase
    end
    hit = (sel != RSEL_NONE);
  end

  always_comb begin
    req_o.sel = sel;
    req_o.hit = hit;
    req_o.rd  = access & ~pwrite & hit;
    req_o.wr  = access &  pwrite & hit;
  end

  // Zero wait states: every access phase completes
  assign pready_o  = access;
  assign pslverr_o = access & ~hit;

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_req_t         req_i,
  input  logic [NPINS-1:0] wbits_i,
  input  logic [NPINS-1:0] pin_evt_i,
  output logic [NPINS-1:0] dout_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] ien_q,
  output logic [NPINS-1:0] sts_q,
  output logic             irq_q
);

  logic             dout_en, dir_en, ien_en, sts_en;
  logic [NPINS-1:0] sts_clr;
  logic [NPINS-1:0] sts_d;
  logic             irq_d;

  // Next-state logic
  always_comb begin
    dout_en = req_i.wr && (req_i.sel == RSEL_DOUT);
    dir_en  = req_i.wr && (req_i.sel == RSEL_DIR);
    ien_en  = req_i.wr && (req_i.sel == RSEL_IEN);
    sts_clr = (req_i.wr && (req_i.sel == RSEL_STAT)) ? wbits_i : '0;
    sts_en  = (|pin_evt_i) | (|sts_clr);
    // A hardware set overrides a same-cycle clear
    sts_d   = (sts_q & ~sts_clr) | pin_evt_i;
    irq_d   = |(sts_q & ien_q);
  end

  // Register processes with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_en) dout_q <= wbits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= wbits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_en) ien_q <= wbits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  localparam int unsigned SYNC_STAGES = 2;

  bus_req_t         req;
  logic [NPINS-1:0] pin_lvl;
  logic [NPINS-1:0] pin_chg;
  logic [NPINS-1:0] dout_q, dir_q, ien_q, sts_q;
  logic [NPINS-1:0] wbits;

  assign wbits = pwdata[NPINS-1:0];

  gpio_pin_sync #(
    .NPINS  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (pclk),
    .rst_n    (presetn),
    .pin_i    (pin_in),
    .level_o  (pin_lvl),
    .change_o (pin_chg)
  );

  gpio_apb_decode #(
    .ADDR_W (ADDR_W)
  ) u_dec (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .req_o     (req),
    .pready_o  (pready),
    .pslverr_o (pslverr)
  );

  gpio_reg_file #(
    .NPINS (NPINS)
  ) u_regs (
    .clk       (pclk),
    .rst_n     (presetn),
    .req_i     (req),
    .wbits_i   (wbits),
    .pin_evt_i (pin_chg),
    .dout_q    (dout_q),
    .dir_q     (dir_q),
    .ien_q     (ien_q),
    .sts_q     (sts_q),
    .irq_q     (irq)
  );

  // Read data, valid in the access phase; zero for misses and writes
  always_comb begin
    prdata = '0;
    if (req.rd) begin
      case (req.sel)
        RSEL_DOUT: prdata[NPINS-1:0] = dout_q;
        RSEL_DIR:  prdata[NPINS-1:0] = dir_q;
        RSEL_PINS: prdata[NPINS-1:0] = pin_lvl;
        RSEL_STAT: prdata[NPINS-1:0] = sts_q;
        RSEL_IEN:  prdata[NPINS-1:0] = ien_q;
        default:   prdata = '0;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = dout_q & dir_q;

endmodule

// File: rtl/gpio_apb_ctrl_chk.sv
module gpio_apb_ctrl_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  dout_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  ien_q,
  input logic [NPINS-1:0]  sts_q,
  input logic [NPINS-1:0]  pin_chg
);

  logic acc, mapped, wr_stat, wr_miss;

  assign acc     = psel && penable;
  assign mapped  = (paddr[1:0] == 2'b00) && (paddr <= ADDR_W'(16));
  assign wr_stat = acc && pwrite && (paddr == ADDR_W'(12));
  assign wr_miss = acc && pwrite && !mapped;

  AST_ZERO_WAIT: assert property (@(posedge pclk) disable iff (!presetn)
    acc |-> pready); // R9

  AST_MAPPED_NO_ERR: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && mapped) |-> !pslverr); // R9

  AST_UNMAPPED_ERR: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && !mapped) |-> (pslverr && prdata == '0)); // R8

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
    $past(wr_miss) |-> (dout_q == $past(dout_q) && dir_q == $past(dir_q) && ien_q == $past(ien_q))); // R8

  AST_OUT_GATED: assert property (@(posedge pclk) disable iff (!presetn)
    (pin_out & ~pin_oe) == '0); // R3

  AST_STS_SET_CAUSE: assert property (@(posedge pclk) disable iff (!presetn)
    ((sts_q & ~$past(sts_q)) != '0) |-> ($past(pin_chg) != '0)); // R5

  AST_STS_CLR_CAUSE: assert property (@(posedge pclk) disable iff (!presetn)
    ((~sts_q & $past(sts_q)) != '0) |-> $past(wr_stat)); // R6

  AST_IRQ_ENABLED: assert property (@(posedge pclk) disable iff (!presetn)
    irq |-> ($past(sts_q & ien_q) != '0)); // R7

endmodule

bind gpio_apb_ctrl gpio_apb_ctrl_chk #(
  .NPINS  (NPINS),
  .ADDR_W (ADDR_W)
) chk_i (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .prdata  (prdata),
  .pready  (pready),
  .pslverr (pslverr),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .irq     (irq),
  .dout_q  (dout_q),
  .dir_q   (dir_q),
  .ien_q   (ien_q),
  .sts_q   (sts_q),
  .pin_chg (pin_chg)
);

// File: tb/gpio_apb_ctrl_tb_top.sv
module gpio_apb_ctrl_tb_top;

  localparam int NP = 32;
  localparam int AW = 12;

  logic          pclk = 1'b0;
  logic          presetn;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [31:0]   pwdata, prdata;
  logic          pready, pslverr;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 pclk = ~pclk;  // 250 MHz

  gpio_apb_ctrl #(.NPINS(NP), .ADDR_W(AW)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Starts at a falling edge: setup now, access next falling edge, ends at a falling edge
  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic err);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    rd  = prdata;
    err = pslverr;
    check("R9 pready", {31'b0, pready}, 32'd1);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic err;
    xfer(1'b1, a, d, rd, err);
    check("R9 mapped write no error", {31'b0, err}, 32'd0);
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] rd; logic err;
    xfer(1'b0, a, 32'h0, rd, err);
    check("R9 mapped read no error", {31'b0, err}, 32'd0);
    check(tag, rd, exp);
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] cur;
    logic [31:0] rd;
    logic err;
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pin_in = '0;
    repeat (4) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    #1;
    // R2: reset state
    check("R2 pin_oe", pin_oe, 32'h0);
    check("R2 pin_out", pin_out, 32'h0);
    check("R2 irq", {31'b0, irq}, 32'h0);
    @(negedge pclk);
    rd_exp(12'h000, 32'h0, "R2 dout reset");
    rd_exp(12'h004, 32'h0, "R2 dir reset");
    rd_exp(12'h008, 32'h0, "R2 input reset");
    rd_exp(12'h00C, 32'h0, "R2 status reset");
    rd_exp(12'h010, 32'h0, "R2 enable reset");

    // R1/R3: walking one and walking zero through the read-write registers
    for (int k = 0; k < 64; k++) begin
      logic [31:0] p;
      logic [31:0] d;
      p = (k < 32) ? (32'h1 << k) : ~(32'h1 << (k - 32));
      d = {p[15:0], p[31:16]} ^ 32'h3C3C_00FF;
      wr(12'h000, p);
      wr(12'h004, d);
      wr(12'h010, ~p);
      rd_exp(12'h000, p, "R1 dout readback");
      rd_exp(12'h004, d, "R1 dir readback");
      rd_exp(12'h010, ~p, "R1 enable readback");
      #1;
      check("R3 pin_oe follows dir", pin_oe, d);
      check("R3 pin_out gated", pin_out, p & d);
    end
    wr(12'h010, 32'h0);
    wr(12'h004, 32'h0);
    wr(12'h000, 32'h0);

    // R4: two-flop latency and read-only input register
    cur = 32'h0;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] nv;
      nv = 32'h1 << i;
      pin_in = nv;
      rd_exp(12'h008, cur, "R4 input still old after one edge");
      rd_exp(12'h008, nv, "R4 input synchronized");
      wr(12'h008, ~nv);
      rd_exp(12'h008, nv, "R4 write to input ignored");
      cur = nv;
    end
    pin_in = '0;
    repeat (5) @(negedge pclk);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd_exp(12'h00C, 32'h0, "R6 clear all status");

    // R5 latency: status appears after the third edge
    pin_in = 32'h0000_0001;
    rd_exp(12'h00C, 32'h0, "R5 status not set after one edge");
    rd_exp(12'h00C, 32'h1, "R5 status set after third edge");
    pin_in = 32'h0000_0003;
    @(negedge pclk);
    rd_exp(12'h00C, 32'h1, "R5 status bit1 not set after two edges");
    rd_exp(12'h00C, 32'h3, "R5 status bit1 set");
    pin_in = '0;
    repeat (5) @(negedge pclk);
    wr(12'h00C, 32'h3);
    rd_exp(12'h00C, 32'h0, "R6 status cleared");

    // R5/R6: per-pin rising then falling edges, W1C with 0 and 1
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 32; i++) begin
        logic [31:0] b;
        b = 32'h1 << i;
        pin_in = pin_in ^ b;
        repeat (5) @(negedge pclk);
        rd_exp(12'h00C, b, pass == 0 ? "R5 rising edge sets bit" : "R5 falling edge sets bit");
        wr(12'h00C, ~b);
        rd_exp(12'h00C, b, "R6 writing 0 keeps bit");
        wr(12'h00C, b);
        rd_exp(12'h00C, 32'h0, "R6 writing 1 clears bit");
      end
    end

    // R6: set wins over a same-edge clear
    pin_in = 32'h8;
    repeat (5) @(negedge pclk);
    rd_exp(12'h00C, 32'h8, "R6 bit3 set before collision");
    pin_in = 32'h0;
    @(negedge pclk);
    wr(12'h00C, 32'h8);
    rd_exp(12'h00C, 32'h8, "R6 set wins over clear");
    wr(12'h00C, 32'h8);
    rd_exp(12'h00C, 32'h0, "R6 clear without event");

    // R7: registered interrupt per pin
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      pin_in = pin_in ^ b;
      repeat (5) @(negedge pclk);
      wr(12'h010, ~b);
      @(negedge pclk); #1;
      check("R7 irq low with bit masked", {31'b0, irq}, 32'h0);
      wr(12'h010, b);
      #1;
      check("R7 irq not yet high", {31'b0, irq}, 32'h0);
      @(negedge pclk); #1;
      check("R7 irq high one clock later", {31'b0, irq}, 32'h1);
      wr(12'h00C, b);
      #1;
      check("R7 irq still high at clear", {31'b0, irq}, 32'h1);
      @(negedge pclk); #1;
      check("R7 irq low after clear", {31'b0, irq}, 32'h0);
    end
    wr(12'h010, 32'h0);

    // R8/R9: address sweep
    wr(12'h000, 32'hA5A5_5A5A);
    wr(12'h004, 32'h0F0F_F0F0);
    pin_in = pin_in ^ 32'h20;
    repeat (5) @(negedge pclk);
    for (int a = 0; a < 76; a++) begin
      logic [AW-1:0] ad;
      bit mapped;
      if (a < 64) ad = AW'(a);
      else        ad = AW'(12'h100 * (a - 63) + (a % 5) * 4);
      mapped = (ad[1:0] == 2'b00) && (ad <= AW'(16));
      xfer(1'b0, ad, 32'h0, rd, err);
      check(mapped ? "R9 no error on mapped read" : "R8 error on unmapped read",
            {31'b0, err}, {31'b0, !mapped});
      if (!mapped) begin
        check("R8 unmapped read returns zero", rd, 32'h0);
        xfer(1'b1, ad, 32'hFFFF_FFFF, rd, err);
        check("R8 error on unmapped write", {31'b0, err}, 32'h1);
      end
    end
    rd_exp(12'h000, 32'hA5A5_5A5A, "R8 dout untouched");
    rd_exp(12'h004, 32'h0F0F_F0F0, "R8 dir untouched");
    rd_exp(12'h010, 32'h0, "R8 enable untouched");
    rd_exp(12'h00C, 32'h20, "R8 status untouched");
    rd_exp(12'h008, 32'hFFFF_FFDF, "R4 input after sweep");
    #1;
    check("R3 pin_out final", pin_out, 32'hA5A5_5A5A & 32'h0F0F_F0F0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule